// File: doc/BRIEF.md
# DSP Pool Control Register Bank

This block lets a host processor manage a group of DSP ports through a small window of memory-mapped registers on a synchronous host bus. Every port gets one control word. The word's bits drive that DSP's reset line, its interrupt request line and the select line of its parallel port. The host therefore steers the whole pool through ordinary bus writes and needs no dedicated pins per port.

In the other direction, every DSP's flag output is brought into the clock domain through a two-stage synchronizer. The synchronized flags are gathered into one read-only status word. They are also combined into a single registered interrupt line toward the host. That line stays high while any synchronized flag is high, so the host drops the request by servicing the DSP that raised its flag. Only one parallel-port select may be active at a time. The bank enforces this in hardware.

Top module: `dsp_pool_ctrl`

## Requirements
- R1: After reset every dsp_rst bit is 1. Every dsp_irq and dsp_sel bit is 0, host_irq is 0 and rdata is 0.
- R2: A write to word offset k, where k < N_PORTS, loads wdata[2:0] into port k's control word. Bit 0 drives dsp_rst[k], bit 1 drives dsp_irq[k] and bit 2 drives dsp_sel[k]. The outputs take the new value on the clock edge that accepts the write.
- R3: A read with rd_en high at offset k < N_PORTS returns port k's control word on rdata in the following cycle. The word sits in bits [2:0] and the upper bits read 0.
- R4: Writing a control word with bit 2 set clears bit 2 of every other port in the same clock edge, so at most one dsp_sel bit is ever 1.
- R5: A write with bit 2 clear changes only the addressed port. Other ports' select bits are unaffected.
- R6: A write to offset N_PORTS or above changes no control word and no output.
- R7: A read at offset N_PORTS returns the status word, with bit k equal to dsp_flag[k] after a two-flop synchronizer. A flag change is readable by a read issued two edges after the change.
- R8: host_irq is the registered OR of the synchronized flags. It rises on the third clock edge after any flag rises, and it falls on the third edge after the last flag falls.
- R9: Reads at offsets above N_PORTS return 0, and rdata is 0 in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | ADDR_W | Word offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after rd_en |
| dsp_flag | input | N_PORTS | Flag outputs of the DSPs, asynchronous |
| dsp_rst | output | N_PORTS | Reset drive per DSP |
| dsp_irq | output | N_PORTS | Interrupt drive per DSP |
| dsp_sel | output | N_PORTS | Parallel-port select per DSP |
| host_irq | output | 1 | Combined interrupt request to the host |

## Verification
On every cycle, the assertions check several properties. The select vector must never hold more than one active bit. A write outside the control window must leave the drive outputs untouched. rdata must be zero whenever no read preceded it. host_irq may only be high if some flag was high three edges earlier. Only the bench's scenarios can show certain other behaviours. These are the exact decode of each control bit, the readback contents, the latency of the synchronizer into both the status word and host_irq, and the interaction of randomly ordered writes and reads across the pool.

// File: rtl/dsp_pool_pkg.sv
package dsp_pool_pkg;

    localparam int CTRL_W  = 3;
    localparam int BIT_RST = 0;
    localparam int BIT_IRQ = 1;
    localparam int BIT_SEL = 2;

    typedef struct packed {
        logic sel;
        logic irq;
        logic rst;
    } port_ctrl_t;

    localparam port_ctrl_t CTRL_RESET = '{sel: 1'b0, irq: 1'b0, rst: 1'b1};

    function automatic port_ctrl_t bits_to_ctrl(input logic [CTRL_W-1:0] b);
        port_ctrl_t c;
        c.rst = b[BIT_RST];
        c.irq = b[BIT_IRQ];
        c.sel = b[BIT_SEL];
        return c;
    endfunction

endpackage

// File: rtl/port_ctrl_regs.sv
module port_ctrl_regs
    import dsp_pool_pkg::*;
#(
    parameter int N_PORTS = 8,
    parameter int ADDR_W  = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [CTRL_W-1:0]    wbits,
    output logic [N_PORTS-1:0]   rst_o,
    output logic [N_PORTS-1:0]   irq_o,
    output logic [N_PORTS-1:0]   sel_o
);
    localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(N_PORTS);

    logic              wr_hit;
    logic [IDX_W-1:0]  widx;
    port_ctrl_t        ctrl_q [N_PORTS];

    assign wr_hit = wr_en && (addr < LIMIT);
    assign widx   = addr[IDX_W-1:0];

    for (genvar k = 0; k < N_PORTS; k++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_q[k] <= CTRL_RESET;
            end else if (wr_hit && (widx == IDX_W'(k))) begin
                ctrl_q[k] <= bits_to_ctrl(wbits);
            end else if (wr_hit && wbits[BIT_SEL]) begin
                ctrl_q[k].sel <= 1'b0;
            end
        end
        assign rst_o[k] = ctrl_q[k].rst;
        assign irq_o[k] = ctrl_q[k].irq;
        assign sel_o[k] = ctrl_q[k].sel;
    end

    // R4
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_o));

    // R6
    unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !(addr < LIMIT)) |=> $stable({rst_o, irq_o, sel_o}));

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&rst_o && !(|irq_o) && !(|sel_o)));

endmodule

// File: rtl/flag_sync.sv
module flag_sync #(
    parameter int N_PORTS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_PORTS-1:0] flag_i,
    output logic [N_PORTS-1:0] status_o,
    output logic               irq_o
);
    logic [N_PORTS-1:0] meta_q;
    logic [N_PORTS-1:0] sync_q;
    logic               irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            meta_q <= flag_i;
            sync_q <= meta_q;
            irq_q  <= |sync_q;
        end
    end

    assign status_o = sync_q;
    assign irq_o    = irq_q;

    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(|flag_i, 3));

endmodule

// File: rtl/rd_mux.sv
module rd_mux
    import dsp_pool_pkg::*;
#(
    parameter int N_PORTS = 8,
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [N_PORTS-1:0] rst_i,
    input  logic [N_PORTS-1:0] irq_i,
    input  logic [N_PORTS-1:0] sel_i,
    input  logic [N_PORTS-1:0] status_i,
    output logic [DATA_W-1:0]  rdata_o
);
    localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
    localparam logic [ADDR_W-1:0] STAT_OFF = ADDR_W'(N_PORTS);

    logic [IDX_W-1:0]  ridx;
    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] rdata_q;

    assign ridx = addr[IDX_W-1:0];

    always_comb begin
        word = '0;
        if (addr < STAT_OFF) begin
            word[BIT_RST] = rst_i[ridx];
            word[BIT_IRQ] = irq_i[ridx];
            word[BIT_SEL] = sel_i[ridx];
        end else if (addr == STAT_OFF) begin
            word[N_PORTS-1:0] = status_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= word;
        else            rdata_q <= '0;
    end

    assign rdata_o = rdata_q;

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en) |-> (rdata_o == '0));

endmodule

// File: rtl/dsp_pool_ctrl.sv
module dsp_pool_ctrl
    import dsp_pool_pkg::*;
#(
    parameter int N_PORTS = 8,
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic [N_PORTS-1:0] dsp_flag,
    output logic [N_PORTS-1:0] dsp_rst,
    output logic [N_PORTS-1:0] dsp_irq,
    output logic [N_PORTS-1:0] dsp_sel,
    output logic               host_irq
);
    logic [N_PORTS-1:0] status;
    logic               unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:CTRL_W];

    port_ctrl_regs #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W)) regs_i (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (addr),
        .wbits (wdata[CTRL_W-1:0]),
        .rst_o (dsp_rst),
        .irq_o (dsp_irq),
        .sel_o (dsp_sel)
    );

    flag_sync #(.N_PORTS(N_PORTS)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .flag_i   (dsp_flag),
        .status_o (status),
        .irq_o    (host_irq)
    );

    rd_mux #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) rd_i (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .addr     (addr),
        .rst_i    (dsp_rst),
        .irq_i    (dsp_irq),
        .sel_i    (dsp_sel),
        .status_i (status),
        .rdata_o  (rdata)
    );

endmodule

// File: tb/dsp_pool_ctrl_tb_top.sv
module dsp_pool_ctrl_tb_top;
    localparam int N  = 8;
    localparam int AW = 6;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [N-1:0]  dsp_flag = '0;
    logic [N-1:0]  dsp_rst, dsp_irq, dsp_sel;
    logic          host_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [N-1:0] m_rst, m_irq, m_sel, m_flag;

    always #10 clk = ~clk;

    dsp_pool_ctrl #(.N_PORTS(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .dsp_flag(dsp_flag), .dsp_rst(dsp_rst),
        .dsp_irq(dsp_irq), .dsp_sel(dsp_sel), .host_irq(host_irq)
    );

    task automatic check(input bit ok, input string req,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_read(input int a);
        logic [DW-1:0] w = '0;
        if (a < N) begin
            w[0] = m_rst[a]; w[1] = m_irq[a]; w[2] = m_sel[a];
        end else if (a == N) begin
            w[N-1:0] = m_flag;
        end
        return w;
    endfunction

    task automatic model_write(input int a, input logic [2:0] b);
        if (a < N) begin
            if (b[2]) m_sel = '0;
            m_rst[a] = b[0]; m_irq[a] = b[1]; m_sel[a] = b[2];
        end
    endtask

    task automatic check_outputs(input string req);
        check(dsp_rst == m_rst, {req, " dsp_rst"}, DW'(dsp_rst), DW'(m_rst));
        check(dsp_irq == m_irq, {req, " dsp_irq"}, DW'(dsp_irq), DW'(m_irq));
        check(dsp_sel == m_sel, {req, " dsp_sel"}, DW'(dsp_sel), DW'(m_sel));
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d, input string req);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d[2:0]);
        check_outputs(req);
    endtask

    task automatic do_read(input int a, input string req);
        logic [DW-1:0] e;
        @(negedge clk);
        rd_en = 1'b1; addr = AW'(a);
        e = exp_read(a);
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        check(rdata == e, req, rdata, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_rst = '1; m_irq = '0; m_sel = '0; m_flag = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check_outputs("R1");
        check(host_irq == 1'b0, "R1 host_irq", DW'(host_irq), 0);
        check(rdata == '0, "R1 rdata", rdata, 0);

        // R2 and R3 directed decode and readback
        do_write(3, 32'hFFFF_FFF2, "R2");
        do_read(3, "R3 port 3 word");
        do_write(0, 32'h0000_0000, "R2 release reset");
        do_read(0, "R3 port 0 word");
        // R4 exclusive select
        do_write(5, 32'h4, "R4 select 5");
        do_write(2, 32'h5, "R4 select 2");
        check(dsp_sel == 8'h04, "R4 only port 2 selected", DW'(dsp_sel), 32'h04);
        // R5 no select change from sel=0 write
        do_write(6, 32'h3, "R5");
        check(dsp_sel == 8'h04, "R5 select kept", DW'(dsp_sel), 32'h04);
        // R6 writes beyond window ignored
        do_write(N, 32'h7, "R6 status offset");
        do_write(N + 5, 32'h7, "R6 unmapped");
        // R9 unmapped read and idle zero
        do_read(N + 3, "R9 unmapped read");
        @(negedge clk);
        check(rdata == '0, "R9 idle rdata", rdata, 0);

        // R7 and R8 flag path timing
        @(negedge clk);
        dsp_flag = 8'h21;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check(host_irq == 1'b0, "R8 not yet high after 2 edges", DW'(host_irq), 0);
        m_flag = 8'h21;
        rd_en = 1'b1; addr = AW'(N);
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        check(rdata == 32'h21, "R7 status after two edges", rdata, 32'h21);
        check(host_irq == 1'b1, "R8 high on third edge", DW'(host_irq), 1);
        dsp_flag = 8'h01;
        repeat (3) @(posedge clk);
        @(negedge clk);
        m_flag = 8'h01;
        check(host_irq == 1'b1, "R8 held by remaining flag", DW'(host_irq), 1);
        do_read(N, "R7 status partial");
        dsp_flag = 8'h00;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check(host_irq == 1'b1, "R8 still high after 2 edges", DW'(host_irq), 1);
        @(posedge clk);
        @(negedge clk);
        m_flag = '0;
        check(host_irq == 1'b0, "R8 falls on third edge", DW'(host_irq), 0);

        // random mix across R2 R3 R4 R5 R6 R7 R9
        for (int i = 0; i < 400; i++) begin
            int a;
            int op;
            a  = int'($urandom_range(0, N + 4));
            op = int'($urandom_range(0, 9));
            if (op < 4) begin
                do_write(a, $urandom(), "R2 random write");
            end else if (op < 8) begin
                do_read(a, "R3 random read");
            end else begin
                logic [N-1:0] f;
                f = N'($urandom());
                @(negedge clk);
                dsp_flag = f;
                repeat (3) @(posedge clk);
                @(negedge clk);
                m_flag = f;
                check(host_irq == (|f), "R8 random flags", DW'(host_irq), DW'(|f));
                do_read(N, "R7 random status");
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule